// File: doc/BRIEF.md
# Sticky ADC Peak Level Meter

This block watches a stream of signed left, right and mono ADC samples. It sorts the absolute value of each sample into coarse decibel bands below full scale. For each channel it keeps the highest band seen since the last readout. The three results are packed into one 8-bit read-only status byte.

Software or a control-port bridge reads that byte by pulsing a read strobe. During the read cycle, the byte shows the values held so far. On the next clock edge every held field returns to zero, so each read reports the peaks for the interval since the previous read.

If a qualifying sample arrives in the same cycle as a read, its band becomes the new starting value for that field. No peak is lost.

Top module: `adc_peak_meter`

## Requirements
- R1: While `rst_ni` is low, and after it rises with no sample accepted, `status_o` is 8'h00.
- R2: Samples are 16-bit two's complement, and the band is taken from the magnitude |s|. For the left and right channels, a non-clipping sample gets code k (1..6), where k is the count of these thresholds that |s| meets or exceeds: 16415, 18399, 20671, 23199, 26015, 29183. Code 0 means |s| < 16415. The thresholds are floor(32767*N/1024) for N = 513, 575, 646, 725, 813, 912, that is, -6, -5, -4, -3, -2 and -1 dB.
- R3: For the mono channel, a non-clipping sample gets code 2 when |s| >= 23199, code 1 when 16415 <= |s| < 23199, and code 0 otherwise.
- R4: Clipping is a sample equal to 32767 or -32768. It gives code 7 on left and right and code 3 on mono. The magnitude of -32768 saturates, so -32767 gives code 6 on left and right and code 2 on mono.
- R5: `status_o[2:0]` carries the left field, `status_o[5:3]` the right field and `status_o[7:6]` the mono field.
- R6: Each field holds the largest code accepted since the last read. A later sample with a lower code leaves the field unchanged.
- R7: In a cycle with `read_i` high, `status_o` shows the pre-clear value. After that edge, with no sample accepted in the same cycle, all fields are zero.
- R8: If `read_i` and `sample_valid_i` are both high in one cycle, each field takes the new sample's code after the edge, even when that code is lower than the value held before.
- R9: With `sample_valid_i` low, the sample inputs are ignored. If `read_i` is also low, `status_o` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Sample words are valid this cycle |
| left_i | input | 16 | Left ADC sample, two's complement |
| right_i | input | 16 | Right ADC sample, two's complement |
| mono_i | input | 16 | Mono ADC sample, two's complement |
| read_i | input | 1 | Status byte read strobe; clears held fields |
| status_o | output | 8 | Packed held peak codes {mono, right, left} |

## Verification
The bench builds the meter with the default 16-bit sample width. At that width the thresholds land on the integer values listed in R2 and R3, so each band edge can be driven exactly, together with the value one below it, on all three channels. The 16-bit width also places the saturating -32768 code and its neighbour -32767 within reach, so clipping can be separated from the top non-clipping band. Ramps and random streams are checked against a max-since-read model, and they include reads that coincide with new samples.

// File: rtl/adc_peak_pkg.sv
package adc_peak_pkg;
  localparam int unsigned LR_CW  = 3;
  localparam int unsigned M_CW   = 2;
  localparam int unsigned N_THR  = 6;
  // thresholds as Q10 fractions of positive full scale: -6..-1 dB
  localparam int unsigned FRAC_Q10 [N_THR] = '{513, 575, 646, 725, 813, 912};
  localparam int unsigned IDX_M6DB = 0;
  localparam int unsigned IDX_M3DB = 3;

  function automatic logic [63:0] thr_f(input int unsigned w, input int unsigned frac);
    logic [63:0] fs;
    fs = (64'd1 << (w - 1)) - 64'd1;
    return (fs * 64'(frac)) >> 10;
  endfunction
endpackage

// File: rtl/adc_abs_mag.sv
module adc_abs_mag #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] sample_i,
  output logic [W-1:0] mag_o,
  output logic         clip_o
);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (sample_i == S_MIN)      mag_o = S_MAX;  // saturate
    else if (sample_i[W-1])     mag_o = -sample_i;
    else                        mag_o = sample_i;
    clip_o = (sample_i == S_MIN) || (sample_i == S_MAX);
  end
endmodule

// File: rtl/adc_band_class.sv
module adc_band_class
  import adc_peak_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter bit          MONO = 1'b0,
  parameter int unsigned CW   = MONO ? M_CW : LR_CW
) (
  input  logic [W-1:0]  sample_i,
  output logic [CW-1:0] code_o
);
  logic [W-1:0]     mag;
  logic             clip;
  logic [N_THR-1:0] ge;

  adc_abs_mag #(.W(W)) u_mag (.sample_i(sample_i), .mag_o(mag), .clip_o(clip));

  for (genvar k = 0; k < N_THR; k++) begin : g_thr
    localparam logic [W-1:0] THR = W'(thr_f(W, FRAC_Q10[k]));
    assign ge[k] = (mag >= THR);
  end

  if (MONO) begin : g_mono
    always_comb begin
      if (clip)                code_o = CW'(3);
      else if (ge[IDX_M3DB])   code_o = CW'(2);
      else if (ge[IDX_M6DB])   code_o = CW'(1);
      else                     code_o = '0;
    end
  end else begin : g_lr
    always_comb begin
      code_o = '0;
      for (int k = 0; k < N_THR; k++)
        if (ge[k]) code_o = CW'(k + 1);
      if (clip) code_o = '1;
    end
  end
endmodule

// File: rtl/adc_peak_hold.sv
module adc_peak_hold #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          clear_i,
  input  logic [CW-1:0] code_i,
  output logic [CW-1:0] held_o
);
  logic [CW-1:0] held_d;

  always_comb begin
    held_d = held_o;
    if (clear_i)                         held_d = valid_i ? code_i : '0;  // restart on collision
    else if (valid_i && code_i > held_o) held_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) held_o <= '0;
    else         held_o <= held_d;
endmodule

// File: rtl/adc_peak_meter.sv
module adc_peak_meter
  import adc_peak_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sample_valid_i,
  input  logic [W-1:0] left_i,
  input  logic [W-1:0] right_i,
  input  logic [W-1:0] mono_i,
  input  logic         read_i,
  output logic [7:0]   status_o
);
  localparam int unsigned N_CH = 3;
  localparam int unsigned CW_A [N_CH] = '{LR_CW, LR_CW, M_CW};
  localparam int unsigned LSB_A [N_CH] = '{0, LR_CW, 2 * LR_CW};

  logic [W-1:0] smp [N_CH];
  assign smp[0] = left_i;
  assign smp[1] = right_i;
  assign smp[2] = mono_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned CW = CW_A[c];
    logic [CW-1:0] code, held;

    adc_band_class #(.W(W), .MONO(c == 2), .CW(CW)) u_cls (
      .sample_i(smp[c]), .code_o(code)
    );
    adc_peak_hold #(.CW(CW)) u_hold (
      .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(sample_valid_i),
      .clear_i(read_i), .code_i(code), .held_o(held)
    );
    assign status_o[LSB_A[c] +: CW] = held;
  end
endmodule

// File: rtl/adc_peak_meter_chk.sv
module adc_peak_meter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sample_valid_i,
  input logic [W-1:0] left_i,
  input logic [W-1:0] right_i,
  input logic [W-1:0] mono_i,
  input logic         read_i,
  input logic [7:0]   status_o
);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  assert_reset_zero_R1: assert property (@(posedge clk_i) !rst_ni |=> status_o == 8'h00 || !rst_ni);

  assert_left_clip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && left_i == S_MAX |=> status_o[2:0] == 3'd7);

  assert_mono_clip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && mono_i == S_MIN |=> status_o[7:6] == 2'd3);

  assert_sticky_left_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i |=> status_o[2:0] >= $past(status_o[2:0]));

  assert_sticky_mono_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i |=> status_o[7:6] >= $past(status_o[7:6]));

  assert_read_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_i && !sample_valid_i |=> status_o == 8'h00);

  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i && !sample_valid_i |=> $stable(status_o));
endmodule

bind adc_peak_meter adc_peak_meter_chk #(.W(W)) u_chk (.*);

// File: tb/tb_adc_peak_meter.sv
module tb_adc_peak_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, rd = 1'b0;
  logic [15:0] l = '0, r = '0, m = '0;
  logic [7:0]  status;
  int checks = 0, fails = 0;
  logic [2:0] hl = '0, hr = '0;
  logic [1:0] hm = '0;

  always #2.5 clk = ~clk;

  adc_peak_meter #(.W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(valid),
    .left_i(l), .right_i(r), .mono_i(m), .read_i(rd), .status_o(status)
  );

  function automatic int mag_f(logic [15:0] s);
    int v = $signed(s);
    if (v == -32768) return 32767;
    return v < 0 ? -v : v;
  endfunction

  function automatic logic [2:0] lr_code(logic [15:0] s);
    int a = mag_f(s);
    if (s == 16'h7fff || s == 16'h8000) return 3'd7;
    if (a >= 29183) return 3'd6;
    if (a >= 26015) return 3'd5;
    if (a >= 23199) return 3'd4;
    if (a >= 20671) return 3'd3;
    if (a >= 18399) return 3'd2;
    if (a >= 16415) return 3'd1;
    return 3'd0;
  endfunction

  function automatic logic [1:0] m_code(logic [15:0] s);
    int a = mag_f(s);
    if (s == 16'h7fff || s == 16'h8000) return 2'd3;
    if (a >= 23199) return 2'd2;
    if (a >= 16415) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: status actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare after the edge
  task automatic step(input logic v, input logic rdv, input logic [15:0] sl,
                      input logic [15:0] sr, input logic [15:0] sm, input string req);
    @(negedge clk);
    valid = v; rd = rdv; l = sl; r = sr; m = sm;
    #1;
    if (rdv) check("R7 pre-clear", status, {hm, hr, hl});
    @(posedge clk);
    if (rdv) begin
      hl = v ? lr_code(sl) : 3'd0;
      hr = v ? lr_code(sr) : 3'd0;
      hm = v ? m_code(sm)  : 2'd0;
    end else if (v) begin
      if (lr_code(sl) > hl) hl = lr_code(sl);
      if (lr_code(sr) > hr) hr = lr_code(sr);
      if (m_code(sm)  > hm) hm = m_code(sm);
    end
    #1;
    check(req, status, {hm, hr, hl});
    @(negedge clk);
    valid = 1'b0; rd = 1'b0;
  endtask

  task automatic do_read(input string req);
    step(1'b0, 1'b1, '0, '0, '0, req);
  endtask

  task automatic t_reset;
    #1 check("R1 in reset", status, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", status, 8'h00);
  endtask

  task automatic t_bands;
    int thr [6] = '{16415, 18399, 20671, 23199, 26015, 29183};
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b0, 16'(thr[k] - 1), '0, 16'(thr[k] - 1), "R2 below threshold");
      step(1'b1, 1'b0, 16'(thr[k]), '0, 16'(thr[k]), "R2 at threshold");
      check("R2 left code", {5'd0, status[2:0]}, 8'(k + 1));
      do_read("R7");
      step(1'b1, 1'b0, '0, 16'(-thr[k]), '0, "R2 negative right");
      check("R5 right field", status, {2'd0, 3'(k + 1), 3'd0});
      do_read("R7");
      step(1'b1, 1'b0, '0, '0, 16'(-thr[k]), "R3 mono band");
      do_read("R7");
    end
  endtask

  task automatic t_clip;
    step(1'b1, 1'b0, 16'h8001, 16'h8001, 16'h8001, "R4 -32767 not clip");
    check("R4 no clip codes", status, {2'd2, 3'd6, 3'd6});
    do_read("R7");
    step(1'b1, 1'b0, 16'h8000, 16'h7fff, 16'h0, "R4 clip lr");
    step(1'b1, 1'b0, 16'h0, 16'h0, 16'h8000, "R4 clip mono");
    check("R5 layout all clip", status, 8'hff);
    do_read("R7");
  endtask

  task automatic t_sticky;
    step(1'b1, 1'b0, 16'd24000, 16'd17000, 16'd17000, "R6 first");
    step(1'b1, 1'b0, 16'd100, 16'd100, 16'd100, "R6 lower sample");
    check("R6 held", status, {2'd1, 3'd1, 3'd4});
    step(1'b0, 1'b0, 16'h7fff, 16'h7fff, 16'h7fff, "R9 ignored");
    check("R9 unchanged", status, {2'd1, 3'd1, 3'd4});
    do_read("R7 clear");
    check("R7 zero", status, 8'h00);
  endtask

  task automatic t_collide;
    step(1'b1, 1'b0, 16'h7fff, 16'h7fff, 16'h7fff, "R8 setup");
    step(1'b1, 1'b1, 16'd17000, 16'd0, 16'd24000, "R8 restart");
    check("R8 lower restart", status, {2'd2, 3'd0, 3'd1});
    do_read("R7");
  endtask

  task automatic t_ramp;
    for (int s = -32768; s < 32768; s += 997) begin
      step(1'b1, 1'b0, 16'(s), 16'(-s), 16'(s), "R6 ramp");
      if ((s & 16'h7) == 0) do_read("R7 ramp");
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      logic [15:0] c = 16'($urandom);
      int sel = $urandom_range(0, 9);
      step(sel != 0, sel >= 8, a, b, c, "R6 random");
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_bands();
        t_clip();
        t_sticky();
        t_collide();
        t_ramp();
        t_random();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule